// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block gathers up to eight interrupt sources into one pending register and forwards a single request line to an upstream interrupt controller. Hardware raises and clears pending bits through two bit-vector strobes. Software reaches the block through a small byte-wide register port with four selectable locations. Through this port it programs a disable mask, acknowledges one source at a time by index, and reads the pending bits back.

The request line is held in a register that reacts to events, not only to the current state. A raise strobe always asserts it, even for a source that is masked. An acknowledge always drops it. A mask write sets it to whether any enabled source is pending. A clear strobe drops it only when no enabled pending source remains. A second controller is kept as a mask location only: writes to it are stored, and it never takes part in the request. The block has no priority resolution, no vector output and no cascading.

Top module: `irq_agg_top`

Register locations, selected by `bus_sel`:
- 0: primary command. A write acknowledges one source. A read returns the pending bits.
- 1: primary mask.
- 2: secondary command.
- 3: secondary mask.

## Requirements
- R1: After reset the pending register is 0, `irq_req` is low and every source is enabled (the stored mask is 0).
- R2: A write to location 1 stores the complement of `bus_wdata` as the enable vector. A written 1 in bit k disables source k.
- R3: In the cycle after a write to location 1, `irq_req` equals the OR of (pending AND new enable), unless a raise strobe occurs in the same cycle.
- R4: A write to location 0 clears pending bit n, where n is `bus_wdata[3:0]`; values 8 to 15 clear nothing. It drops `irq_req` in the next cycle unless a raise strobe occurs in the same cycle.
- R5: A nonzero `hw_raise` ORs its bits into the pending register. It sets `irq_req` in the next cycle whatever the enable vector holds.
- R6: A nonzero `hw_clear` removes its bits from the pending register. It drops `irq_req` only if no enabled source remains pending; otherwise `irq_req` keeps its value.
- R7: `bus_rdata` (combinational) returns the pending bits, zero-extended, when `bus_sel` is 0, and returns 0 for locations 1, 2 and 3.
- R8: A write to location 3 is stored and changes neither `irq_req` nor the pending register. A write to location 2 is ignored.
- R9: When a raise and a clear or acknowledge hit the same bit in the same cycle, the raise wins: the bit ends up pending and `irq_req` high.
- R10: The next pending value is always (pending AND NOT clear AND NOT acknowledged bit) OR raise. Event priority for `irq_req` is raise, then acknowledge, then mask write, then clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register location select |
| bus_wr | input | 1 | Write strobe for the selected location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected location |
| hw_raise | input | 8 | Bit vector of sources to set pending |
| hw_clear | input | 8 | Bit vector of sources to clear from pending |
| irq_req | output | 1 | Request line to the upstream controller |

## Verification
The hardest situation to reach is a collision in one cycle: a raise strobe together with a clear, an acknowledge or a mask write that targets the same bit. Only this collision shows the resolution order of the request register. Random stimulus rarely lines these up on one bit, so directed steps set each collision up explicitly. A constrained random run with sparse strobes and acknowledge indices biased into the low nibble then mixes them with ordinary traffic. Masked raises, where the request asserts with no enabled bit pending, and acknowledges with indices 8 to 15 are also driven on purpose, because a state-based model would get both wrong.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    SEL_PCMD  = 2'd0,
    SEL_PMASK = 2'd1,
    SEL_SCMD  = 2'd2,
    SEL_SMASK = 2'd3
  } sel_e;

  localparam int SRC_N_DEF  = 8;
  localparam int DATA_W_DEF = 8;
  localparam int ACK_IDX_W  = 4;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int NSRC = SRC_N_DEF,
  parameter int IDXW = ACK_IDX_W
) (
  input  logic [1:0]      sel,
  input  logic            wr,
  input  logic [IDXW-1:0] idx,
  output logic            ack_evt,
  output logic            mask_evt,
  output logic            sec_evt,
  output logic [NSRC-1:0] ack_vec
);
  // index to one-hot; out-of-range indices give an empty vector
  function automatic logic [NSRC-1:0] idx_to_vec(input logic [IDXW-1:0] n);
    logic [NSRC-1:0] v;
    v = '0;
    for (int i = 0; i < NSRC; i++)
      if (32'(n) == i) v[i] = 1'b1;
    return v;
  endfunction

  sel_e s;
  assign s        = sel_e'(sel);
  assign ack_evt  = wr && (s == SEL_PCMD);
  assign mask_evt = wr && (s == SEL_PMASK);
  assign sec_evt  = wr && (s == SEL_SMASK);
  assign ack_vec  = ack_evt ? idx_to_vec(idx) : '0;

  always_comb begin
    assert_ack_single_R4: assert ($onehot0(ack_vec));
  end
endmodule

// File: rtl/irq_agg_pending.sv
module irq_agg_pending
  import irq_agg_pkg::*;
#(
  parameter int NSRC = SRC_N_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raise_vec,
  input  logic [NSRC-1:0] clear_vec,
  input  logic [NSRC-1:0] ack_vec,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] pend_nx
);
  // removals first, then raises on top so a raise wins a collision
  function automatic logic [NSRC-1:0] next_pend(
    input logic [NSRC-1:0] p, input logic [NSRC-1:0] r,
    input logic [NSRC-1:0] c, input logic [NSRC-1:0] a);
    return (p & ~c & ~a) | r;
  endfunction

  assign pend_nx = next_pend(pend_q, raise_vec, clear_vec, ack_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nx;
  end

  assert_raise_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(raise_vec)) == $past(raise_vec)));

  assert_clear_removes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clear_vec & ~raise_vec)) == '0));

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(raise_vec)) == '0));
endmodule

// File: rtl/irq_agg_request.sv
module irq_agg_request
  import irq_agg_pkg::*;
#(
  parameter int NSRC = SRC_N_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raise_evt,
  input  logic            ack_evt,
  input  logic            mask_evt,
  input  logic            clear_evt,
  input  logic [NSRC-1:0] pend_nx,
  input  logic [NSRC-1:0] en_nx,
  output logic            irq_q
);
  logic live;
  assign live = |(pend_nx & en_nx);

  // event priority: raise, acknowledge, mask write, clear
  function automatic logic req_next(input logic cur, input logic r,
    input logic a, input logic m, input logic c, input logic l);
    if (r)      return 1'b1;
    else if (a) return 1'b0;
    else if (m) return l;
    else if (c) return cur & l;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= req_next(irq_q, raise_evt, ack_evt, mask_evt, clear_evt, live);
  end

  assert_raise_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    raise_evt |=> irq_q);

  assert_ack_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !raise_evt) |=> !irq_q);

  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(raise_evt || mask_evt));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NSRC = SRC_N_DEF,
  parameter int DW   = DATA_W_DEF,
  parameter int IDXW = ACK_IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_sel,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NSRC-1:0] hw_raise,
  input  logic [NSRC-1:0] hw_clear,
  output logic          irq_req
);
  logic            ack_evt, mask_evt, sec_evt;
  logic            raise_evt, clear_evt;
  logic [NSRC-1:0] ack_vec, pend_q, pend_nx, en_nx;
  logic [NSRC-1:0] mask_q;
  logic [DW-1:0]   smask_q;

  assign raise_evt = |hw_raise;
  assign clear_evt = |hw_clear;

  irq_agg_decode #(.NSRC(NSRC), .IDXW(IDXW)) u_decode (
    .sel(bus_sel), .wr(bus_wr), .idx(bus_wdata[IDXW-1:0]),
    .ack_evt(ack_evt), .mask_evt(mask_evt), .sec_evt(sec_evt),
    .ack_vec(ack_vec));

  irq_agg_pending #(.NSRC(NSRC)) u_pending (
    .clk(clk), .rst_n(rst_n), .raise_vec(hw_raise), .clear_vec(hw_clear),
    .ack_vec(ack_vec), .pend_q(pend_q), .pend_nx(pend_nx));

  // the stored mask is the written byte; enable is its complement
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      smask_q <= '0;
    end else begin
      if (mask_evt) mask_q  <= bus_wdata[NSRC-1:0];
      if (sec_evt)  smask_q <= bus_wdata;
    end
  end

  assign en_nx = mask_evt ? ~bus_wdata[NSRC-1:0] : ~mask_q;

  irq_agg_request #(.NSRC(NSRC)) u_request (
    .clk(clk), .rst_n(rst_n), .raise_evt(raise_evt), .ack_evt(ack_evt),
    .mask_evt(mask_evt), .clear_evt(clear_evt), .pend_nx(pend_nx),
    .en_nx(en_nx), .irq_q(irq_req));

  always_comb begin
    bus_rdata = '0;
    if (sel_e'(bus_sel) == SEL_PCMD) bus_rdata = DW'(pend_q);
  end

  assert_sec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_evt |=> $stable(smask_q));

  assert_mask_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |=> (mask_q == $past(bus_wdata[NSRC-1:0])));
endmodule

// File: tb/test_irq_agg_top.sv
module test_irq_agg_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [7:0] hw_raise = 8'd0;
  logic [7:0] hw_clear = 8'd0;
  logic       irq_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] m_pend = 8'd0;
  logic [7:0] m_en = 8'hFF;
  logic       m_irq = 1'b0;
  string      prev_tag = "R1";

  always #5 clk = ~clk;

  irq_agg_top i_irq_agg_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_raise(hw_raise),
    .hw_clear(hw_clear), .irq_req(irq_req));

  function automatic logic [7:0] src_bit(input logic [3:0] n);
    return (n < 4'd8) ? (8'd1 << n) : 8'd0;
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] s, input logic [7:0] p);
    return (s == 2'd0) ? p : 8'd0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] s, input logic w, input logic [7:0] d,
                      input logic [7:0] r, input logic [7:0] c, input string tag);
    logic [7:0] np, ne, ab;
    logic       ni, live;
    bus_sel = s; bus_wr = w; bus_wdata = d; hw_raise = r; hw_clear = c;
    #1;
    check({prev_tag, " read"}, bus_rdata, exp_read(s, m_pend));
    check({prev_tag, " irq"}, {7'd0, irq_req}, {7'd0, m_irq});
    ab   = (w && s == 2'd0) ? src_bit(d[3:0]) : 8'd0;
    np   = r | (m_pend & ~(c | ab));
    ne   = (w && s == 2'd1) ? ~d : m_en;
    live = (np & ne) != 8'd0;
    ni   = m_irq;
    if (c != 8'd0 && !live) ni = 1'b0;
    if (w && s == 2'd1) ni = live;
    if (w && s == 2'd0) ni = 1'b0;
    if (r != 8'd0) ni = 1'b1;
    @(posedge clk);
    m_pend = np; m_en = ne; m_irq = ni; prev_tag = tag;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rr, cc, dd;
    logic [1:0] ss;
    logic       ww;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, all sources enabled
    step(2'd0, 1'b0, 8'd0, 8'h08, 8'd0, "R5");
    step(2'd1, 1'b1, 8'h08, 8'd0, 8'd0, "R2");
    step(2'd0, 1'b0, 8'd0, 8'd0, 8'd0, "R3");
    step(2'd1, 1'b1, 8'h00, 8'd0, 8'd0, "R3");
    step(2'd0, 1'b1, 8'h03, 8'd0, 8'd0, "R4");
    step(2'd0, 1'b0, 8'd0, 8'h05, 8'd0, "R5");
    step(2'd0, 1'b1, 8'h0C, 8'd0, 8'd0, "R4");
    step(2'd0, 1'b0, 8'd0, 8'h02, 8'h02, "R9");
    step(2'd0, 1'b0, 8'd0, 8'd0, 8'h05, "R6");
    step(2'd0, 1'b1, 8'h01, 8'h02, 8'd0, "R9");
    step(2'd3, 1'b1, 8'hFF, 8'd0, 8'd0, "R8");
    step(2'd2, 1'b1, 8'h01, 8'd0, 8'd0, "R8");
    step(2'd1, 1'b1, 8'h02, 8'd0, 8'd0, "R7");
    step(2'd0, 1'b0, 8'd0, 8'h80, 8'd0, "R5");
    step(2'd0, 1'b0, 8'd0, 8'd0, 8'h80, "R6");
    step(2'd1, 1'b1, 8'h00, 8'd0, 8'h02, "R10");
    for (int i = 0; i < 4000; i++) begin
      ss = 2'($urandom % 4);
      ww = ($urandom % 3) == 0;
      dd = (ss == 2'd0) ? 8'($urandom % 12) : 8'($urandom);
      rr = (($urandom % 4) == 0) ? 8'($urandom) & 8'($urandom) : 8'd0;
      cc = (($urandom % 4) == 0) ? 8'($urandom) | 8'($urandom) : 8'd0;
      step(ss, ww, dd, rr, cc, "R10");
    end
    step(2'd0, 1'b0, 8'd0, 8'd0, 8'd0, "R7");
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule